// File: doc/BRIEF.md
# Double-Buffered Address-Event Capture

This block takes address events from an asynchronous address-event bus that uses a four-phase request/acknowledge handshake. The request line passes through a two-flop synchronizer, and a handshake state machine answers it. Each captured address is written into whichever of two event banks is currently filling. Meanwhile a downstream consumer reads, at its own pace, the bank that was completed most recently.

When the filling bank holds `DEPTH` events, the two banks change roles by toggling one bank pointer. No data is copied. A one-cycle `swap_pulse` tells the consumer that a new bank is ready. The consumer hands a bank back with a one-cycle `cons_ready` pulse.

The block has two modes, selected by `hold_mode`:
- **Free-running (`hold_mode` low):** the swap never waits. A bank the consumer has not handed back is simply reused, and the loss is reported on `drop_count`.
- **Hold (`hold_mode` high):** the swap waits for the hand-back. During the wait the acknowledge of the final event is withheld, which stalls the sender, so no event is ever lost.

State machine states and transitions:
- `ST_IDLE`: acknowledge is low. It moves to `ST_TAKE` when the synchronized request is high.
- `ST_TAKE`: the address is written into the fill bank. Normally it moves to `ST_ACK`; if this is the final event of the bank, it swaps on the way. In hold mode, when the consumer still owns its bank, it moves to `ST_STALL` instead.
- `ST_STALL`: acknowledge is held low. It swaps and moves to `ST_ACK` once the bank has been handed back.
- `ST_ACK`: acknowledge is high. It moves back to `ST_IDLE` once the synchronized request has gone low.

Top module: `aer_pingpong_capture`

## Requirements
- R1: `ack_out` rises only in response to a request. It first goes high no earlier than the fourth rising clock edge after `req_in` rises: two edges for the synchronizer, one to enter `ST_TAKE`, one to take the address.
- R2: After `req_in` falls, `ack_out` falls three rising edges later. It stays high for as long as the synchronized request is high, so the bus sees two acknowledge changes per event.
- R3: Events are stored in arrival order. After a swap, `rd_data` for `rd_idx` = k (k from 0 to `DEPTH`-1) returns the k-th address of the completed bank. The address is sampled while the block is in `ST_TAKE`; changes to `addr_in` after `ack_out` rises have no effect.
- R4: The `DEPTH`-th event of a fill causes a swap. `rd_bank` toggles, and `swap_pulse` is high for exactly one cycle: the first cycle in which `ack_out` is high for that event. No other event changes `rd_bank` or raises `swap_pulse`.
- R5: Back-to-back bursts (request raised again straight after acknowledge falls) and randomly spaced events are all captured, with none lost or reordered.
- R6: With `hold_mode` low, a swap never waits. `drop_count` is updated at each swap: it reads `DEPTH` if the consumer had not handed back its bank with a `cons_ready` pulse since the previous swap, and 0 otherwise. The very first swap reports 0.
- R7: With `hold_mode` high, if the consumer still owns its bank when the final event of a fill is taken, `ack_out` stays low until a `cons_ready` pulse arrives; then the swap occurs. `drop_count` then reads 0.
- R8: Reset drives `ack_out`, `swap_pulse` and `drop_count` to 0. It sets the fill pointer to bank 0, so `rd_bank` reads 1. It clears the fill count, so the first `DEPTH` events complete the first fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_in | input | 1 | Asynchronous event request from the sender |
| addr_in | input | ADDR_W | Event address, stable while `req_in` is high |
| ack_out | output | 1 | Handshake acknowledge to the sender |
| hold_mode | input | 1 | 1: swap waits for the consumer hand-back; 0: free-running |
| cons_ready | input | 1 | One-cycle pulse: consumer hands back its bank |
| rd_idx | input | IDX_W | Read index into the completed bank |
| rd_data | output | ADDR_W | Address stored at `rd_idx` in the completed bank |
| rd_bank | output | 1 | Index of the bank the consumer owns |
| swap_pulse | output | 1 | One-cycle notification that the banks swapped |
| drop_count | output | CNT_W | Events lost at the most recent swap |

## Verification
The assertions check on every cycle the handshake rules: acknowledge never rises without a synchronized request, and it falls right after the request does. They also check that each swap pulse lasts one cycle, toggles the bank index and coincides with acknowledge, that the bank index is stable between swaps, and that hold mode never reports drops. Only the bench scenarios can show the rest: addresses landing in arrival order at the right indices, the exact handshake latencies, the stall of the final event until the hand-back arrives, and `DEPTH` being reported after an unreturned bank in free-running mode.

// File: rtl/aer_cap_pkg.sv
package aer_cap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TAKE  = 2'd1,
        ST_STALL = 2'd2,
        ST_ACK   = 2'd3
    } hs_state_t;
endpackage

// File: rtl/aer_req_sync.sv
module aer_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/aer_bank_pair.sv
module aer_bank_pair #(
    parameter int ADDR_W = 10,
    parameter int DEPTH  = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic              wr_bank,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              rd_bank,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_data
);
    logic [ADDR_W-1:0] bank_word [2];

    // One storage array per bank; the bank pointer only steers access.
    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [ADDR_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (we && (wr_bank == 1'(b))) store[wr_idx] <= wr_data;
        end

        assign bank_word[b] = store[rd_idx];
    end

    assign rd_data = bank_word[rd_bank];
endmodule

// File: rtl/aer_hs_ctrl.sv
module aer_hs_ctrl
    import aer_cap_pkg::*;
#(
    parameter int DEPTH  = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_sync,
    input  logic             hold_mode,
    input  logic             cons_ready,
    output logic             ack,
    output logic             we,
    output logic [IDX_W-1:0] wr_idx,
    output logic             fill_bank,
    output logic             swap_pulse,
    output logic [CNT_W-1:0] drop_count
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    hs_state_t        state, state_n;
    logic [IDX_W-1:0] fill_cnt;
    logic             pending;
    logic             released;
    logic             do_swap;
    logic             last_slot;

    assign released  = !pending || cons_ready;
    assign last_slot = (fill_cnt == LAST_IDX);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Next state and per-state outputs
    always_comb begin
        state_n = state;
        we      = 1'b0;
        do_swap = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_sync) state_n = ST_TAKE;
            end
            ST_TAKE: begin
                we = 1'b1;
                if (last_slot) begin
                    if (hold_mode && !released) begin
                        state_n = ST_STALL;
                    end else begin
                        do_swap = 1'b1;
                        state_n = ST_ACK;
                    end
                end else begin
                    state_n = ST_ACK;
                end
            end
            ST_STALL: begin
                if (released) begin
                    do_swap = 1'b1;
                    state_n = ST_ACK;
                end
            end
            ST_ACK: begin
                if (!req_sync) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    assign ack    = (state == ST_ACK);
    assign wr_idx = fill_cnt;

    // Fill count, bank pointer, ownership and notification
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_cnt   <= '0;
            fill_bank  <= 1'b0;
            pending    <= 1'b0;
            swap_pulse <= 1'b0;
            drop_count <= '0;
        end else begin
            swap_pulse <= do_swap;
            if (do_swap) begin
                fill_cnt   <= '0;
                fill_bank  <= ~fill_bank;
                pending    <= 1'b1;
                drop_count <= released ? '0 : FULL_CNT;
            end else begin
                if (we) fill_cnt <= fill_cnt + 1'b1;
                if (cons_ready) pending <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/aer_pingpong_capture.sv
module aer_pingpong_capture #(
    parameter int ADDR_W = 10,
    parameter int DEPTH  = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_in,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              ack_out,
    input  logic              hold_mode,
    input  logic              cons_ready,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_data,
    output logic              rd_bank,
    output logic              swap_pulse,
    output logic [CNT_W-1:0]  drop_count
);
    logic             req_sync;
    logic             we;
    logic [IDX_W-1:0] wr_idx;
    logic             fill_bank;

    aer_req_sync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (req_in),
        .dout (req_sync)
    );

    aer_hs_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_sync  (req_sync),
        .hold_mode (hold_mode),
        .cons_ready(cons_ready),
        .ack       (ack_out),
        .we        (we),
        .wr_idx    (wr_idx),
        .fill_bank (fill_bank),
        .swap_pulse(swap_pulse),
        .drop_count(drop_count)
    );

    assign rd_bank = ~fill_bank;

    aer_bank_pair #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_banks (
        .clk    (clk),
        .we     (we),
        .wr_bank(fill_bank),
        .wr_idx (wr_idx),
        .wr_data(addr_in),
        .rd_bank(rd_bank),
        .rd_idx (rd_idx),
        .rd_data(rd_data)
    );
endmodule

// File: rtl/aer_cap_checker.sv
module aer_cap_checker #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_sync,
    input logic             ack_out,
    input logic             hold_mode,
    input logic             rd_bank,
    input logic             swap_pulse,
    input logic [CNT_W-1:0] drop_count
);
    assert_no_spurious_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_out && !req_sync) |=> !ack_out);

    assert_ack_falls_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_out && !req_sync) |=> !ack_out);

    assert_ack_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_out && req_sync) |=> ack_out);

    assert_swap_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        swap_pulse |=> !swap_pulse);

    assert_swap_toggles_R4: assert property (@(posedge clk) disable iff (!rst_n)
        swap_pulse |-> (rd_bank != $past(rd_bank)));

    assert_bank_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !swap_pulse |-> $stable(rd_bank));

    assert_swap_with_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        swap_pulse |-> ack_out);

    assert_hold_no_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (swap_pulse && hold_mode && $past(hold_mode)) |-> (drop_count == '0));
endmodule

bind aer_pingpong_capture aer_cap_checker #(.CNT_W(CNT_W)) u_cap_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_sync  (req_sync),
    .ack_out   (ack_out),
    .hold_mode (hold_mode),
    .rd_bank   (rd_bank),
    .swap_pulse(swap_pulse),
    .drop_count(drop_count)
);

// File: tb/aer_pingpong_capture_bench.sv
module aer_pingpong_capture_bench;
    localparam int ADDR_W = 10;
    localparam int DEPTH  = 16;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_in = 1'b0;
    logic [ADDR_W-1:0] addr_in = '0;
    logic              ack_out;
    logic              hold_mode = 1'b0;
    logic              cons_ready = 1'b0;
    logic [IDX_W-1:0]  rd_idx = '0;
    logic [ADDR_W-1:0] rd_data;
    logic              rd_bank;
    logic              swap_pulse;
    logic [CNT_W-1:0]  drop_count;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // Bench model
    int              cnt_m     = 0;
    bit              pending_m = 1'b0;
    bit              bank_m    = 1'b1;
    logic [ADDR_W-1:0] fill_m [DEPTH];
    logic [ADDR_W-1:0] done_m [DEPTH];

    always #4 clk = ~clk;

    aer_pingpong_capture #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_aer_pingpong_capture (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .addr_in(addr_in),
        .ack_out(ack_out), .hold_mode(hold_mode), .cons_ready(cons_ready),
        .rd_idx(rd_idx), .rd_data(rd_data), .rd_bank(rd_bank),
        .swap_pulse(swap_pulse), .drop_count(drop_count)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int expected_drop(input bit hold, input bit pend);
        return (!hold && pend) ? DEPTH : 0;
    endfunction

    task automatic release_bank();
        @(negedge clk) cons_ready = 1'b1;
        @(negedge clk) cons_ready = 1'b0;
        pending_m = 1'b0;
    endtask

    task automatic read_back();
        for (int k = 0; k < DEPTH; k++) begin
            rd_idx = IDX_W'(k);
            #1;
            check(rd_data == done_m[k], "R3 stored order", int'(rd_data), int'(done_m[k]));
        end
    endtask

    task automatic send_event(input logic [ADDR_W-1:0] a, input int gap);
        bit is_last;
        bit stall;
        int waited;
        int exp_drop;
        is_last  = (cnt_m == DEPTH - 1);
        stall    = is_last && hold_mode && pending_m;
        exp_drop = expected_drop(hold_mode, pending_m);
        fill_m[cnt_m] = a;
        @(negedge clk);
        addr_in = a;
        req_in  = 1'b1;
        waited  = 0;
        if (stall) begin
            bit low_all;
            low_all = 1'b1;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                waited++;
                if (ack_out) low_all = 1'b0;
            end
            check(low_all, "R7 ack withheld during hold", int'(low_all), 1);
            cons_ready = 1'b1;
            @(negedge clk);
            cons_ready = 1'b0;
            pending_m = 1'b0;
            waited++;
        end
        while (!ack_out && waited < 100) begin
            @(negedge clk);
            waited++;
        end
        check(ack_out, "R5 event acknowledged", int'(ack_out), 1);
        check(waited >= 4, "R1 ack latency", waited, 4);
        if (is_last) begin
            bank_m = ~bank_m;
            check(swap_pulse == 1'b1, "R4 swap pulse on final event", int'(swap_pulse), 1);
            check(rd_bank == bank_m, "R4 bank toggled", int'(rd_bank), int'(bank_m));
            check(int'(drop_count) == exp_drop, hold_mode ? "R7 no drop" : "R6 drop count",
                  int'(drop_count), exp_drop);
            for (int k = 0; k < DEPTH; k++) done_m[k] = fill_m[k];
            pending_m = 1'b1;
            cnt_m = 0;
        end else begin
            check(swap_pulse == 1'b0, "R4 no swap mid fill", int'(swap_pulse), 0);
            cnt_m++;
        end
        // Address changes after acknowledge must be ignored (R3)
        addr_in = ADDR_W'($urandom);
        req_in  = 1'b0;
        waited  = 0;
        while (ack_out && waited < 100) begin
            @(negedge clk);
            waited++;
        end
        check(!ack_out && waited == 3, "R2 ack release latency", waited, 3);
        if (is_last) read_back();
        for (int g = 0; g < gap; g++) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R8 reset state
        check(ack_out == 1'b0, "R8 ack low in reset", int'(ack_out), 0);
        check(swap_pulse == 1'b0, "R8 swap low in reset", int'(swap_pulse), 0);
        check(rd_bank == 1'b1, "R8 read bank after reset", int'(rd_bank), 1);
        check(drop_count == '0, "R8 drop clear", int'(drop_count), 0);
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R5 back-to-back burst, free mode: first swap reports 0 (R6)
        for (int i = 0; i < DEPTH; i++) send_event(ADDR_W'(i * 37 + 5), 0);
        // R6 consumer never returned bank: next swap reports DEPTH
        for (int i = 0; i < DEPTH; i++) send_event(ADDR_W'(1000 - i), 0);
        // R6 returned bank: 0
        release_bank();
        for (int i = 0; i < DEPTH; i++) send_event(ADDR_W'(i ^ 10'h2A5), 1);

        // R7 hold mode: final event stalls until hand-back
        hold_mode = 1'b1;
        for (int i = 0; i < DEPTH; i++) send_event(ADDR_W'(i + 300), 0);
        // R7 hold mode with bank already returned: no stall
        release_bank();
        for (int i = 0; i < DEPTH; i++) send_event(ADDR_W'(i * 3), 2);

        // R5 random spacing, random modes and hand-backs
        for (int blk = 0; blk < 10; blk++) begin
            hold_mode = 1'($urandom_range(0, 1));
            for (int i = 0; i < DEPTH; i++) begin
                if ($urandom_range(0, 7) == 0) release_bank();
                send_event(ADDR_W'($urandom), $urandom_range(0, 5));
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule